// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an asynchronous serial line back into characters. The line passes through a two-flop synchroniser and is then sampled using an oversampling tick that an external baud generator supplies. The tick arrives 16 times per bit period. The frame format is chosen at run time and matches the companion transmitter:

- 5 to 9 data bits.
- No parity, even parity or odd parity.
- One or two stop bits. The receiver checks only the first stop bit.

Bits collect in a shift buffer. At the middle of the first stop bit, the finished character moves into a read register and a receive-complete flag is raised. Frame and parity status travel with the character. The shift buffer is then free at once, so the next frame can shift in while the previous character is still waiting to be read. A one-cycle read strobe takes the held character. If a further character completes before that read, the overrun flag is raised.

Top module: `uart_rx`

## Requirements
- R1: After a synchronous reset, `rx_ready`, `err_frame`, `err_parity` and `err_overrun` are all low and `rx_data` is zero.
- R2: A frame begins with a low start bit that follows a high line. Data bits arrive least-significant first, and the character appears right-justified on `rx_data` with all unused upper bits zero.
- R3: The size code `cfg_size` gives the number of data bits: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. Any other code gives 8.
- R4: The parity code `cfg_parity` selects the parity mode: 00 is none, 10 is even, 11 is odd, and 01 is none. In even mode the parity bit equals the XOR of the data bits; in odd mode it is the inverse of that XOR. A matching parity bit leaves `err_parity` low.
- R5: If the received parity bit differs from the parity computed from the received data bits, `err_parity` is high together with that character.
- R6: If the first stop bit is sampled low, `err_frame` is high together with that character, and the character is still delivered.
- R7: If a character completes while the previous one is still unread, `rx_data` keeps the unread character, the new character is discarded, and `err_overrun` goes high.
- R8: The receiver returns to idle at the middle of the first stop bit. A frame whose start bit immediately follows a single stop bit is received correctly.
- R9: A low pulse that has returned high by the start bit's mid-point sample is a false start. The receiver goes back to idle and delivers no character, and a frame sent afterwards is received normally.
- R10: A `rd_stb` pulse while `rx_ready` is high clears both `rx_ready` and `err_overrun` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit period |
| rx_line | input | 1 | Asynchronous serial input; idles high |
| cfg_size | input | 3 | Data bit count code |
| cfg_parity | input | 2 | Parity mode code |
| rd_stb | input | 1 | One-cycle read strobe for the held character |
| rx_data | output | 9 | Held character, right-justified |
| rx_ready | output | 1 | Receive complete: a character is waiting to be read |
| err_frame | output | 1 | First stop bit of the held character was low |
| err_parity | output | 1 | Parity of the held character mismatched |
| err_overrun | output | 1 | A character was lost because the held one was unread |

## Verification
The bench sends characters with alternating and clustered bit patterns at every data size, so that a wrong bit order or a wrong field width shows up in the value. Even and odd parity are each sent with a correct parity bit and with an inverted one, which separates the two polarities from each other and from the parity-error detection. A low stop bit, frames sent back to back with no idle gap, and a short glitch on the idle line test the stop sampling, the return to idle and the rejection of false starts. Two frames left unread, followed by a read and a third frame, show that the held character is kept on overrun and that the read clears the overrun flag.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 9;
    localparam int BCNT_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
        logic              perr;
    } rx_char_t;

    // Number of data bits selected by the size code
    function automatic logic [BCNT_W-1:0] size_to_bits(input logic [2:0] code);
        case (code)
            3'b000:  return BCNT_W'(5);
            3'b001:  return BCNT_W'(6);
            3'b010:  return BCNT_W'(7);
            3'b111:  return BCNT_W'(9);
            default: return BCNT_W'(8);
        endcase
    endfunction

    function automatic logic parity_on(input logic [1:0] mode);
        return mode[1];
    endfunction

    // Right-justify a buffer that was filled from the top
    function automatic logic [DATA_W-1:0] align_char(input logic [DATA_W-1:0] buf_q,
                                                     input logic [BCNT_W-1:0] nbits);
        return buf_q >> (BCNT_W'(DATA_W) - nbits);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       line,
    input  logic [2:0] cfg_size,
    input  logic [1:0] cfg_parity,
    output logic       done,
    output rx_char_t   char_out
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID_T  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST_T = CNT_W'(OSR - 1);

    rx_state_e         state_q;
    logic [CNT_W-1:0]  tcnt_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic [BCNT_W-1:0] nbits_q;
    logic [1:0]        pmode_q;
    logic [DATA_W-1:0] shbuf_q;
    logic              pbit_q;
    logic              prev_hi_q;
    logic              calc_par;

    // Unfilled low bits are zero, so XOR over the whole buffer equals XOR of the data
    assign calc_par = ^shbuf_q ^ pmode_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            tcnt_q    <= '0;
            bcnt_q    <= '0;
            nbits_q   <= BCNT_W'(8);
            pmode_q   <= 2'b00;
            shbuf_q   <= '0;
            pbit_q    <= 1'b0;
            prev_hi_q <= 1'b0;
            done      <= 1'b0;
            char_out  <= '0;
        end else begin
            done <= 1'b0;
            if (os_tick) begin
                case (state_q)
                    ST_IDLE: begin
                        prev_hi_q <= line;
                        if (prev_hi_q && !line) begin
                            state_q <= ST_START;
                            tcnt_q  <= '0;
                            nbits_q <= size_to_bits(cfg_size);
                            pmode_q <= cfg_parity;
                        end
                    end
                    ST_START: begin
                        if (tcnt_q == MID_T) begin
                            tcnt_q <= '0;
                            if (line) begin
                                state_q   <= ST_IDLE;
                                prev_hi_q <= 1'b1;
                            end else begin
                                state_q <= ST_DATA;
                                bcnt_q  <= '0;
                                shbuf_q <= '0;
                            end
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (tcnt_q == LAST_T) begin
                            tcnt_q  <= '0;
                            shbuf_q <= {line, shbuf_q[DATA_W-1:1]};
                            if (bcnt_q == nbits_q - 1'b1)
                                state_q <= parity_on(pmode_q) ? ST_PARITY : ST_STOP;
                            else
                                bcnt_q <= bcnt_q + 1'b1;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_PARITY: begin
                        if (tcnt_q == LAST_T) begin
                            tcnt_q  <= '0;
                            pbit_q  <= line;
                            state_q <= ST_STOP;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (tcnt_q == LAST_T) begin
                            tcnt_q        <= '0;
                            done          <= 1'b1;
                            char_out.data <= align_char(shbuf_q, nbits_q);
                            char_out.ferr <= !line;
                            char_out.perr <= parity_on(pmode_q) && (pbit_q != calc_par);
                            state_q       <= ST_IDLE;
                            prev_hi_q     <= line;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_START && os_tick && tcnt_q == MID_T && line) |=> (state_q == ST_IDLE && !done)); // R9

    AST_STOP_FREES_BUFFER: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP && os_tick && tcnt_q == LAST_T) |=> (state_q == ST_IDLE && done)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2

    AST_NO_PERR_WITHOUT_PARITY: assert property (@(posedge clk) disable iff (rst)
        (done && !parity_on(pmode_q)) |-> !char_out.perr); // R4
endmodule

// File: rtl/uart_rx_holdreg.sv
module uart_rx_holdreg
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_char_t          char_in,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_overrun
);
    logic read_now;
    assign read_now = rd_stb && rx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_overrun <= 1'b0;
        end else if (done && (!rx_ready || read_now)) begin
            rx_data     <= char_in.data;
            err_frame   <= char_in.ferr;
            err_parity  <= char_in.perr;
            rx_ready    <= 1'b1;
            err_overrun <= 1'b0;
        end else if (done) begin
            err_overrun <= 1'b1;
        end else if (read_now) begin
            rx_ready    <= 1'b0;
            err_overrun <= 1'b0;
        end
    end

    AST_LOAD_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (done && !(rx_ready && !rd_stb)) |=> (rx_ready && rx_data == $past(char_in.data))); // R2

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (done && rx_ready && !rd_stb) |=> (err_overrun && $stable(rx_data) && rx_ready)); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rx_ready && !done) |=> (!rx_ready && !err_overrun)); // R10

    AST_NO_OVERRUN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |-> !err_overrun); // R7
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rx_line,
    input  logic [2:0] cfg_size,
    input  logic [1:0] cfg_parity,
    input  logic       rd_stb,
    output logic [8:0] rx_data,
    output logic       rx_ready,
    output logic       err_frame,
    output logic       err_parity,
    output logic       err_overrun
);
    logic     line_s;
    logic     done;
    rx_char_t char_w;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (line_s)
    );

    uart_rx_framer #(.OSR(OSR)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .os_tick    (os_tick),
        .line       (line_s),
        .cfg_size   (cfg_size),
        .cfg_parity (cfg_parity),
        .done       (done),
        .char_out   (char_w)
    );

    uart_rx_holdreg u_hold (
        .clk         (clk),
        .rst         (rst),
        .done        (done),
        .char_in     (char_w),
        .rd_stb      (rd_stb),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .err_frame   (err_frame),
        .err_parity  (err_parity),
        .err_overrun (err_overrun)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!rx_ready && !err_overrun)); // R1
endmodule

// File: tb/uart_rx_tb_top.sv
module uart_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [2:0] cfg_size = 3'b011;
    logic [1:0] cfg_parity = 2'b00;
    logic       mon_stb = 1'b0;
    logic       man_stb = 1'b0;
    logic       rd_stb;
    logic [8:0] rx_data;
    logic       rx_ready, err_frame, err_parity, err_overrun;

    assign rd_stb = mon_stb | man_stb;

    uart_rx dut_i (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line),
        .cfg_size(cfg_size), .cfg_parity(cfg_parity), .rd_stb(rd_stb),
        .rx_data(rx_data), .rx_ready(rx_ready), .err_frame(err_frame),
        .err_parity(err_parity), .err_overrun(err_overrun)
    );

    always #4 clk = ~clk;
    always @(posedge clk) os_tick <= ~os_tick;

    typedef struct {
        logic [8:0] data;
        logic       fe;
        logic       pe;
        string      req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   mon_en = 1'b0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int nbits_of(input logic [2:0] c);
        case (c)
            3'b000:  return 5;
            3'b001:  return 6;
            3'b010:  return 7;
            3'b111:  return 9;
            default: return 8;
        endcase
    endfunction

    task automatic hold_bit(input logic v);
        rx_line = v;
        repeat (32) @(negedge clk);
    endtask

    // Driver: sends one frame and pushes the expected character
    task automatic send(input logic [8:0] d, input bit bad_par, input bit bad_stop,
                        input int gap, input bit push, input string req);
        int         n;
        logic [8:0] dm;
        logic       pb;
        exp_t       e;
        n  = nbits_of(cfg_size);
        dm = d & 9'((1 << n) - 1);
        hold_bit(1'b0);
        for (int i = 0; i < n; i++) hold_bit(dm[i]);
        if (cfg_parity[1]) begin
            pb = (^dm) ^ cfg_parity[0];
            if (bad_par) pb = ~pb;
            hold_bit(pb);
        end
        if (push) begin
            e.data = dm; e.fe = bad_stop; e.pe = bad_par && cfg_parity[1]; e.req = req;
            q.push_back(e);
        end
        hold_bit(!bad_stop);
        for (int g = 0; g < gap; g++) hold_bit(1'b1);
    endtask

    task automatic drain(input string req);
        repeat (80) @(negedge clk);
        check(q.size() == 0, req, "items left in queue", q.size(), 0);
    endtask

    task automatic manual_read();
        man_stb = 1'b1;
        @(negedge clk);
        man_stb = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pops expected items as characters appear
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && rx_ready) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2", "unexpected character", rx_data, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(rx_data == e.data, e.req, "data", rx_data, e.data);
                    check(err_frame == e.fe, e.req, "frame flag", err_frame, e.fe);
                    check(err_parity == e.pe, e.req, "parity flag", err_parity, e.pe);
                    check(!err_overrun, e.req, "overrun flag", err_overrun, 0);
                end
                mon_stb = 1'b1;
                @(negedge clk);
                mon_stb = 1'b0;
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!rx_ready, "R1", "rx_ready", rx_ready, 0);
        check(!err_frame && !err_parity && !err_overrun, "R1", "flags",
              {err_frame, err_parity, err_overrun}, 0);
        check(rx_data == 9'h0, "R1", "rx_data", rx_data, 0);
        hold_bit(1'b1); hold_bit(1'b1);
        mon_en = 1'b1;

        // R2 eight bits, no parity
        send(9'h0A5, 0, 0, 1, 1, "R2");
        send(9'h03C, 0, 0, 1, 1, "R2");
        // R3 each size code
        cfg_size = 3'b000; send(9'h1F3, 0, 0, 1, 1, "R3");
        cfg_size = 3'b001; send(9'h02A, 0, 0, 1, 1, "R3");
        cfg_size = 3'b010; send(9'h055, 0, 0, 1, 1, "R3");
        cfg_size = 3'b111; send(9'h1A5, 0, 0, 1, 1, "R3");
        cfg_size = 3'b101; send(9'h1C3, 0, 0, 1, 1, "R3");
        cfg_size = 3'b011;
        // R4 good parity, both polarities
        cfg_parity = 2'b10; send(9'h05A, 0, 0, 1, 1, "R4");
        send(9'h007, 0, 0, 1, 1, "R4");
        cfg_parity = 2'b11; send(9'h05A, 0, 0, 1, 1, "R4");
        send(9'h080, 0, 0, 1, 1, "R4");
        cfg_parity = 2'b01; send(9'h0F0, 0, 0, 1, 1, "R4");
        // R5 wrong parity bit
        cfg_parity = 2'b10; send(9'h033, 1, 0, 1, 1, "R5");
        cfg_parity = 2'b11; send(9'h0C1, 1, 0, 1, 1, "R5");
        cfg_size = 3'b000;  send(9'h015, 1, 0, 1, 1, "R5");
        cfg_size = 3'b011;  cfg_parity = 2'b00;
        // R6 low stop bit
        send(9'h0C3, 0, 1, 2, 1, "R6");
        // R8 back-to-back frames with one stop bit
        send(9'h011, 0, 0, 0, 1, "R8");
        send(9'h022, 0, 0, 0, 1, "R8");
        send(9'h033, 0, 0, 1, 1, "R8");
        drain("R8");

        // R9 short glitch then a real frame
        rx_line = 1'b0;
        repeat (8) @(negedge clk);
        hold_bit(1'b1); hold_bit(1'b1); hold_bit(1'b1);
        check(!rx_ready, "R9", "rx_ready after glitch", rx_ready, 0);
        check(q.size() == 0, "R9", "queue after glitch", q.size(), 0);
        send(9'h069, 0, 0, 1, 1, "R9");
        drain("R9");

        // R7 overrun: two characters, no read in between
        mon_en = 1'b0;
        send(9'h001, 0, 0, 1, 0, "R7");
        send(9'h002, 0, 0, 1, 0, "R7");
        check(rx_ready, "R7", "rx_ready", rx_ready, 1);
        check(rx_data == 9'h001, "R7", "held data", rx_data, 1);
        check(err_overrun, "R7", "overrun flag", err_overrun, 1);
        // R10 read clears
        manual_read();
        check(!rx_ready, "R10", "rx_ready after read", rx_ready, 0);
        check(!err_overrun, "R10", "overrun after read", err_overrun, 0);
        send(9'h003, 0, 0, 1, 0, "R7");
        check(rx_data == 9'h003, "R7", "data after recovery", rx_data, 3);
        check(!err_overrun, "R7", "no overrun after read", err_overrun, 0);
        manual_read();
        check(!rx_ready, "R10", "rx_ready after second read", rx_ready, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule